// File: doc/BRIEF.md
# Predicated Bundle Issue Control

This block sits between instruction fetch and the execute stage of an in-order, multi-lane pipeline. Each incoming 32-bit instruction word carries a 2-bit tag in its top two bits. The tag either chains the word to the next one in a wide bundle, marks it as the final (or only) member of a bundle, or makes it conditional on a single status bit T. The block collects words into bundles of up to three lanes. It hands each bundle to execute as one unit. At execute it turns each lane's tag and the current T into a write/side-effect enable.

Conditional lanes are resolved only at execute, so the shape of the pipeline is fixed before the outcome is known. A lane that is predicated off still occupies its lane and its execute cycle. Its destination register also still counts for the read-after-write interlock. Only its enable is withheld. A bundle whose source registers name a destination of the bundle currently in execute is held for one cycle, and this happens whether or not that older lane actually writes.

Fetch presents one word per cycle with `in_valid` and waits on `in_ready`. The execute stage sees one bundle per cycle on the `ex_*` outputs. T (`t_flag`) must be valid during the cycle in which the bundle is in execute, and all lanes of that bundle use that single value.

Top module: `predicated_issue_ctrl`

## Requirements
- R1: The tag is word bits [31:30]. A word with tag 2'b11 continues the open bundle; a word with tag 2'b00, 2'b01 or 2'b10 closes it. Every word appears exactly once on `ex_lanes`, in arrival order, with the first word of a bundle in lane 0 (bits [31:0]).
- R2: A bundle holds at most 3 lanes. A tag-11 word that arrives while 2 words are already held is placed in lane 2 and closes the bundle. That bundle is delivered with `ex_bad` high and all three lane-valid bits set. `ex_bad` is low for every other bundle.
- R3: A valid lane with tag 2'b00 has its bit in `ex_wr_en` equal to `t_flag` during its execute cycle.
- R4: A valid lane with tag 2'b01 has its bit in `ex_wr_en` equal to the inverse of `t_flag` during its execute cycle.
- R5: A valid lane with tag 2'b10 or 2'b11 always has its `ex_wr_en` bit set.
- R6: `ex_lane_valid` is set for every lane of the bundle, including lanes that are predicated off. It is contiguous from lane 0, with `ex_valid` equal to bit 0. An `ex_wr_en` bit is never set for an invalid lane.
- R7: Register fields are rd = [29:25], rs1 = [24:20] and rs2 = [19:15]. If any rs1 or rs2 of a bundle equals the rd of any valid lane of the bundle in execute, the bundle enters execute one cycle later, leaving an empty execute cycle. This applies even when that lane is predicated off.
- R8: Two bundles with no such register match enter execute on consecutive cycles.
- R9: During reset `ex_valid`, `ex_lane_valid`, `ex_wr_en` and `ex_bad` are 0 and `in_ready` is 1.
- R10: `in_ready` falls while a formed bundle is held by the interlock, and no word offered during that time is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Fetch offers `in_word` |
| in_word | input | 32 | Tagged instruction word |
| in_ready | output | 1 | Word is taken on this edge when `in_valid` is high |
| t_flag | input | 1 | Status bit T for the bundle in execute |
| ex_valid | output | 1 | A bundle is in execute this cycle |
| ex_lanes | output | 96 | Lane words, lane 0 in bits [31:0] |
| ex_lane_valid | output | 3 | Lane occupancy, predicated-off lanes included |
| ex_wr_en | output | 3 | Per-lane result and side-effect enable |
| ex_bad | output | 1 | Bundle exceeded the lane limit |

## Verification
The assertions check the following on every cycle:
- lane occupancy is contiguous and no enable is raised for an empty lane;
- flagged bundles are full;
- each conditional lane's enable follows T in the right sense, and unconditional lanes are always enabled;
- two bundles in execute on consecutive cycles never have a register dependency between them.

Only the bench's scenarios can show the following:
- whole bundles form in the right grouping and order;
- a dependent bundle behind a predicated-off producer is delayed by exactly one cycle;
- independent bundles flow without a gap;
- the input is stalled without losing words.

// File: rtl/pbi_pkg.sv
// Package: shared word layout, tag encoding and field extractors for the
// predicated bundle issue control. Assumes 32-bit words with tag at the top.
package pbi_pkg;
    localparam int WORD_W = 32;
    localparam int REG_W  = 5;
    localparam int RD_LO  = 25;
    localparam int RS1_LO = 20;
    localparam int RS2_LO = 15;

    typedef enum logic [1:0] {
        TAG_IF_T = 2'b00,
        TAG_IF_F = 2'b01,
        TAG_LAST = 2'b10,
        TAG_MORE = 2'b11
    } tag_e;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [REG_W-1:0]  reg_t;

    function automatic tag_e tag_of(word_t w);
        return tag_e'(w[WORD_W-1 -: 2]);
    endfunction

    function automatic reg_t rd_of(word_t w);
        return w[RD_LO +: REG_W];
    endfunction

    function automatic reg_t rs1_of(word_t w);
        return w[RS1_LO +: REG_W];
    endfunction

    function automatic reg_t rs2_of(word_t w);
        return w[RS2_LO +: REG_W];
    endfunction
endpackage

// File: rtl/pbi_former.sv
// Module: bundle former. Gathers accepted words into an open bundle and
// reports the closing word together with the assembled lanes.
// Assumes: take is only high when the downstream issue slot can load.
module pbi_former
    import pbi_pkg::*;
#(
    parameter int LANES = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take,
    input  word_t                         word,
    output logic                          close,
    output logic                          bad,
    output logic [LANES-1:0][WORD_W-1:0]  out_w,
    output logic [LANES-1:0]              out_m
);
    localparam int CW = (LANES > 2) ? $clog2(LANES) : 1;

    logic [LANES-1:0][WORD_W-1:0] buf_q;
    logic [CW-1:0]                cnt_q;
    tag_e                         tg;
    logic                         last_slot;

    assign tg        = tag_of(word);
    assign last_slot = (cnt_q == CW'(LANES-1));
    assign close     = take & ((tg != TAG_MORE) | last_slot);
    assign bad       = take & (tg == TAG_MORE) & last_slot;

    // Assemble held words plus the incoming word into lane order.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (CW'(i) < cnt_q)       out_w[i] = buf_q[i];
            else if (CW'(i) == cnt_q) out_w[i] = word;
            else                      out_w[i] = '0;
            out_m[i] = (CW'(i) <= cnt_q);
        end
    end

    // Hold non-final words; restart the count when a bundle closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            buf_q <= '0;
        end else if (take) begin
            if (close) begin
                cnt_q <= '0;
            end else begin
                buf_q[cnt_q] <= word;
                cnt_q        <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/pbi_raw_check.sv
// Module: read-after-write detector. Compares every source of the bundle
// waiting to issue with every destination of the bundle in execute.
// Assumes: execute lanes count regardless of their predicate outcome.
module pbi_raw_check
    import pbi_pkg::*;
#(
    parameter int LANES = 3
) (
    input  logic [LANES-1:0][WORD_W-1:0] iss_w,
    input  logic [LANES-1:0]             iss_m,
    input  logic [LANES-1:0][WORD_W-1:0] ex_w,
    input  logic [LANES-1:0]             ex_m,
    output logic                         hazard
);
    // Any source/destination match across the two bundles raises the hazard.
    always_comb begin
        hazard = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < LANES; j++) begin
                if (iss_m[i] && ex_m[j] &&
                    ((rs1_of(iss_w[i]) == rd_of(ex_w[j])) ||
                     (rs2_of(iss_w[i]) == rd_of(ex_w[j]))))
                    hazard = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pbi_exec_stage.sv
// Module: execute-stage register and predicate resolution. Holds one bundle
// per cycle and derives each lane's enable from its tag and T.
// Assumes: t_flag is valid in the cycle the bundle sits in this stage.
module pbi_exec_stage
    import pbi_pkg::*;
#(
    parameter int LANES = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [LANES-1:0][WORD_W-1:0]  in_w,
    input  logic [LANES-1:0]              in_m,
    input  logic                          in_bad,
    input  logic                          t_flag,
    output logic [LANES-1:0][WORD_W-1:0]  ex_w,
    output logic [LANES-1:0]              ex_m,
    output logic                          ex_bad,
    output logic [LANES-1:0]              wr_en
);
    // Capture an issuing bundle or insert an empty slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !load) begin
            ex_w   <= '0;
            ex_m   <= '0;
            ex_bad <= 1'b0;
        end else begin
            ex_w   <= in_w;
            ex_m   <= in_m;
            ex_bad <= in_bad;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tag_e tg;
        logic pass;
        assign tg = tag_of(ex_w[g]);
        // Decide whether this lane's effects are kept under the shared T.
        always_comb begin
            case (tg)
                TAG_IF_T: pass = t_flag;
                TAG_IF_F: pass = ~t_flag;
                default:  pass = 1'b1;
            endcase
        end
        assign wr_en[g] = ex_m[g] & pass;
    end
endmodule

// File: rtl/predicated_issue_ctrl.sv
// Module: top of the predicated bundle issue control. Forms bundles from
// tagged words, holds one formed bundle in an issue slot, interlocks it on
// register dependencies against execute, and resolves predicates there.
// Assumes: one word per cycle from fetch; single-cycle execute latency.
module predicated_issue_ctrl
    import pbi_pkg::*;
#(
    parameter int LANES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [31:0]              in_word,
    output logic                     in_ready,
    input  logic                     t_flag,
    output logic                     ex_valid,
    output logic [LANES*32-1:0]      ex_lanes,
    output logic [LANES-1:0]         ex_lane_valid,
    output logic [LANES-1:0]         ex_wr_en,
    output logic                     ex_bad
);
    logic                         take, close, bad, hazard, iss_go;
    logic [LANES-1:0][WORD_W-1:0] form_w, iss_w, ex_w;
    logic [LANES-1:0]             form_m, iss_m, ex_m;
    logic                         iss_valid, iss_bad;

    assign iss_go   = iss_valid & ~hazard;
    assign in_ready = ~iss_valid | iss_go;
    assign take     = in_valid & in_ready;

    pbi_former #(.LANES(LANES)) u_form (
        .clk(clk), .rst_n(rst_n), .take(take), .word(in_word),
        .close(close), .bad(bad), .out_w(form_w), .out_m(form_m)
    );

    // Issue slot: loads a closed bundle, empties when it moves to execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_w     <= '0;
            iss_m     <= '0;
            iss_bad   <= 1'b0;
        end else if (close) begin
            iss_valid <= 1'b1;
            iss_w     <= form_w;
            iss_m     <= form_m;
            iss_bad   <= bad;
        end else if (iss_go) begin
            iss_valid <= 1'b0;
        end
    end

    pbi_raw_check #(.LANES(LANES)) u_raw (
        .iss_w(iss_w), .iss_m(iss_m & {LANES{iss_valid}}),
        .ex_w(ex_w), .ex_m(ex_m), .hazard(hazard)
    );

    pbi_exec_stage #(.LANES(LANES)) u_exec (
        .clk(clk), .rst_n(rst_n), .load(iss_go),
        .in_w(iss_w), .in_m(iss_m), .in_bad(iss_bad), .t_flag(t_flag),
        .ex_w(ex_w), .ex_m(ex_m), .ex_bad(ex_bad), .wr_en(ex_wr_en)
    );

    assign ex_lanes      = ex_w;
    assign ex_lane_valid = ex_m;
    assign ex_valid      = ex_m[0];
endmodule

// File: rtl/pbi_checker.sv
// Module: property checker for predicated_issue_ctrl, attached by bind.
// Observes ports only, plus its own copy of the previous execute bundle.
module pbi_checker
    import pbi_pkg::*;
#(
    parameter int LANES = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                t_flag,
    input logic                ex_valid,
    input logic [LANES*32-1:0] ex_lanes,
    input logic [LANES-1:0]    ex_lane_valid,
    input logic [LANES-1:0]    ex_wr_en,
    input logic                ex_bad
);
    logic [LANES*32-1:0] prev_w;
    logic [LANES-1:0]    prev_m;
    logic [LANES:0]      m_plus;
    logic                dep_hit;

    // Remember the bundle that was in execute on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_w <= '0;
            prev_m <= '0;
        end else begin
            prev_w <= ex_lanes;
            prev_m <= ex_lane_valid;
        end
    end

    // Register dependency between the current and previous execute bundles.
    always_comb begin
        dep_hit = 1'b0;
        for (int i = 0; i < LANES; i++)
            for (int j = 0; j < LANES; j++)
                if (ex_lane_valid[i] && prev_m[j] &&
                    ((rs1_of(ex_lanes[i*32 +: 32]) == rd_of(prev_w[j*32 +: 32])) ||
                     (rs2_of(ex_lanes[i*32 +: 32]) == rd_of(prev_w[j*32 +: 32]))))
                    dep_hit = 1'b1;
    end

    assign m_plus = {1'b0, ex_lane_valid} + 1'b1;

    p_raw_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dep_hit);

    p_wr_in_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_wr_en & ~ex_lane_valid) == '0);

    p_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_plus[LANES-1:0] & ex_lane_valid) == '0);

    p_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid == ex_lane_valid[0]);

    p_bad_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bad |-> (&ex_lane_valid));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        logic [1:0] tg;
        assign tg = ex_lanes[g*32+30 +: 2];

        p_if_true_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_lane_valid[g] && tg == 2'b00) |-> (ex_wr_en[g] == t_flag));

        p_if_false_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_lane_valid[g] && tg == 2'b01) |-> (ex_wr_en[g] == !t_flag));

        p_uncond_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_lane_valid[g] && tg[1]) |-> ex_wr_en[g]);
    end
endmodule

bind predicated_issue_ctrl pbi_checker #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .t_flag(t_flag), .ex_valid(ex_valid),
    .ex_lanes(ex_lanes), .ex_lane_valid(ex_lane_valid),
    .ex_wr_en(ex_wr_en), .ex_bad(ex_bad)
);

// File: tb/sim_predicated_issue_ctrl.sv
// Bench: directed corner cases plus seeded random tagged words, checked
// against a bundle model kept in the bench.
module sim_predicated_issue_ctrl;
    localparam int LANES = 3;
    localparam int LW    = LANES*32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [31:0]      in_word = '0;
    logic             in_ready;
    logic             t_flag = 1'b0;
    logic             ex_valid;
    logic [LW-1:0]    ex_lanes;
    logic [LANES-1:0] ex_lane_valid, ex_wr_en;
    logic             ex_bad;

    int  checks = 0, errors = 0, cyc = 0, last_ex = -100, last_gap = 0;
    bit  started = 0, t_rand = 0, saw_stall = 0;

    typedef struct packed {
        logic [LW-1:0]    w;
        logic [LANES-1:0] m;
        logic             bad;
        logic             dep;
    } bexp_t;
    bexp_t         expq[$];
    logic [LW-1:0] cur_w = '0, last_w = '0;
    logic [LANES-1:0] last_m = '0;
    int            cur_n = 0;

    always #5 clk = ~clk;

    predicated_issue_ctrl #(.LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .t_flag(t_flag), .ex_valid(ex_valid),
        .ex_lanes(ex_lanes), .ex_lane_valid(ex_lane_valid),
        .ex_wr_en(ex_wr_en), .ex_bad(ex_bad)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] tg, input int rd,
                                       input int s1, input int s2);
        return {tg, rd[4:0], s1[4:0], s2[4:0], 15'h1a5};
    endfunction

    function automatic bit dep_of(input logic [LW-1:0] nw, input logic [LANES-1:0] nm,
                                  input logic [LW-1:0] ow, input logic [LANES-1:0] om);
        for (int i = 0; i < LANES; i++)
            for (int j = 0; j < LANES; j++)
                if (nm[i] && om[j] &&
                    (nw[i*32+20 +: 5] == ow[j*32+25 +: 5] ||
                     nw[i*32+15 +: 5] == ow[j*32+25 +: 5]))
                    return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [LANES-1:0] exp_wr(input logic [LW-1:0] w,
                                                input logic [LANES-1:0] m, input logic t);
        logic [LANES-1:0] e;
        for (int i = 0; i < LANES; i++) begin
            logic [1:0] tg;
            tg = w[i*32+30 +: 2];
            e[i] = m[i] & ((tg == 2'b00) ? t : (tg == 2'b01) ? !t : 1'b1);
        end
        return e;
    endfunction

    // Bench bundle model: R1 grouping and R2 lane limit.
    task automatic model_word(input logic [31:0] w);
        bexp_t b;
        cur_w[cur_n*32 +: 32] = w;
        cur_n++;
        if (w[31:30] != 2'b11 || cur_n == LANES) begin
            b.w   = cur_w;
            b.m   = LANES'((1 << cur_n) - 1);
            b.bad = (w[31:30] == 2'b11);
            b.dep = dep_of(b.w, b.m, last_w, last_m);
            expq.push_back(b);
            last_w = b.w; last_m = b.m;
            cur_w = '0; cur_n = 0;
        end
    endtask

    task automatic send(input logic [31:0] w);
        bit r;
        in_valid = 1'b1;
        in_word  = w;
        forever begin
            r = in_ready;
            @(negedge clk);
            if (r) break;
        end
        model_word(w);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) cyc++;
    always @(posedge clk) if (t_rand) #2 t_flag = 1'($urandom_range(0, 1));

    // Output monitor: compares each execute bundle with the model.
    always @(negedge clk) begin
        if (started && rst_n) begin
            if (!in_ready) saw_stall = 1;
            if (ex_valid) begin
                if (expq.size() == 0) begin
                    chk(0, "R1 unexpected bundle", ex_lanes, '0);
                end else begin
                    bexp_t e;
                    e = expq.pop_front();
                    chk(ex_lanes == e.w, "R1 lane words", ex_lanes, e.w);
                    chk(ex_lane_valid == e.m, "R6 lane valid", LW'(ex_lane_valid), LW'(e.m));
                    chk(ex_bad == e.bad, "R2 bad flag", LW'(ex_bad), LW'(e.bad));
                    chk(ex_wr_en == exp_wr(e.w, e.m, t_flag), "R3/R4/R5 enables",
                        LW'(ex_wr_en), LW'(exp_wr(e.w, e.m, t_flag)));
                    last_gap = cyc - last_ex;
                    if (e.dep)
                        chk(last_gap >= 2, "R7 dependent bundle gap", LW'(last_gap), LW'(2));
                    last_ex = cyc;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20260517));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(ex_valid == 0, "R9 ex_valid", LW'(ex_valid), '0);
        chk(ex_lane_valid == 0 && ex_wr_en == 0, "R9 lanes/enables",
            LW'({ex_lane_valid, ex_wr_en}), '0);
        chk(ex_bad == 0, "R9 ex_bad", LW'(ex_bad), '0);
        chk(in_ready == 1, "R9 in_ready", LW'(in_ready), LW'(1));
        rst_n = 1'b1;
        started = 1;
        @(negedge clk);

        // R8: independent scalars flow back to back
        t_flag = 1'b0;
        send(mk(2'b10, 1, 2, 3));
        send(mk(2'b10, 4, 5, 6));
        idle(5);
        chk(last_gap == 1, "R8 independent gap", LW'(last_gap), LW'(1));

        // R7/R10: predicated-off producer (T=0, tag 00) still interlocks
        saw_stall = 0;
        send(mk(2'b00, 7, 1, 1));
        send(mk(2'b10, 2, 7, 0));
        idle(5);
        chk(last_gap == 2, "R7 off-lane interlock gap", LW'(last_gap), LW'(2));
        chk(saw_stall, "R10 in_ready dropped", LW'(saw_stall), LW'(1));

        // R2: four chained words then a final one
        t_flag = 1'b1;
        send(mk(2'b11, 8, 9, 9));
        send(mk(2'b11, 10, 9, 9));
        send(mk(2'b11, 11, 9, 9));
        send(mk(2'b11, 12, 9, 9));
        send(mk(2'b10, 13, 9, 9));
        idle(5);

        // R3/R4/R5: mixed predicates in one bundle under both T values
        send(mk(2'b11, 14, 20, 21));
        send(mk(2'b11, 15, 20, 21));
        send(mk(2'b00, 16, 20, 21));
        idle(4);
        t_flag = 1'b0;
        send(mk(2'b11, 17, 22, 23));
        send(mk(2'b01, 18, 22, 23));
        idle(4);
        send(mk(2'b11, 19, 24, 25));
        send(mk(2'b00, 26, 24, 25));
        idle(4);

        // Random mix with frequent register collisions
        t_rand = 1;
        for (int n = 0; n < 800; n++) begin
            int r;
            logic [1:0] tg;
            r  = $urandom_range(0, 9);
            tg = (r < 3) ? 2'b11 : (r < 5) ? 2'b00 : (r < 7) ? 2'b01 : 2'b10;
            send(mk(tg, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)));
            if ($urandom_range(0, 5) == 0) idle(1);
        end
        send(mk(2'b10, 30, 31, 31));
        idle(12);
        chk(expq.size() == 0, "R1 all bundles delivered", LW'(expq.size()), '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule